// File: doc/BRIEF.md
# ADC Channel-Gain Sequencer

This block chooses which analog input, gain step, range class and input reference the front end applies to each conversion. It keeps a list of up to `DEPTH` packed entries. On every conversion pulse it moves to the next entry, and after the last filled entry it returns to the first. Software builds the list in three steps: it issues a clear command, turns the list on, and then writes the entries one after another. Each write goes to the next free slot.

When the list is turned off, a separate one-entry holding register drives the outputs. Software writes that register through its own strobe, and it serves single-channel acquisition. The outputs are the decoded fields of whichever entry is active. They follow the stored state combinationally, so every change appears in the clock cycle after the write or pulse that causes it.

Top module: `cgs_sequencer`

## Requirements
- R1: Entry bits [3:0] appear on `chan_o` and entry bits [6:4] appear on `gain_o` for the active entry.
- R2: Entry bits [9:8] appear unchanged on `rclass_o`: 00 means bipolar 5 V, 01 means bipolar 10 V and 10 means unipolar 10 V.
- R3: `ref_o` is 2'b10 (differential) when entry bit 10 is set, 2'b01 (common) when only bit 7 is set, and 2'b00 (ground) when both are clear. Bit 10 wins when both are set.
- R4: When the list is disabled, the outputs show the holding register. `latch_wr_i` loads that register with `wdata_i`, and conversion pulses change nothing.
- R5: A `tbl_clr_i` strobe empties the list, moves the read position to entry 0 and clears `ovf_o`. It takes priority over a write in the same cycle.
- R6: Each `tbl_wr_i` strobe stores `wdata_i` in the next free slot. With the list enabled, each `conv_i` pulse moves the outputs to the following entry.
- R7: A `conv_i` pulse on the last filled entry returns the outputs to entry 0.
- R8: An `en_wr_i` strobe with `en_val_i` = 1 enables the list and moves the read position to entry 0. An `en_wr_i` strobe with `en_val_i` = 0 disables the list.
- R9: An enabled but empty list drives the holding register value.
- R10: A write to a full list of `DEPTH` entries stores nothing and sets `ovf_o`. `ovf_o` stays set until the next clear.
- R11: After reset, the list is disabled and empty, the holding register is zero, every output is zero and `ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_clr_i | input | 1 | Clear command for the list |
| tbl_wr_i | input | 1 | Append `wdata_i` to the list |
| latch_wr_i | input | 1 | Load `wdata_i` into the holding register |
| en_wr_i | input | 1 | Write the list enable |
| en_val_i | input | 1 | Enable value written by `en_wr_i` |
| wdata_i | input | 11 | Entry data for list and holding register |
| conv_i | input | 1 | Conversion pulse, advances the list |
| chan_o | output | 4 | Active channel |
| gain_o | output | 3 | Active gain index |
| rclass_o | output | 2 | Active range class |
| ref_o | output | 2 | Active reference mode |
| ovf_o | output | 1 | Sticky list overflow flag |

## Verification
A wrong fill count shows up in two ways. The outputs wrap one entry early or one entry late. Or an overflowing write becomes visible as an extra entry, which the bench exposes by stepping through a full list and watching the wrap. A wrong read position gives the wrong entry on the very next sample after a conversion pulse, a clear or an enable write, because the outputs are combinational from the stored state. A wrong select between the list and the holding register appears within one cycle of an enable change.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
   localparam int ENTRY_W = 11;

   typedef enum logic [1:0] {
      REF_GND  = 2'b00,
      REF_COM  = 2'b01,
      REF_DIFF = 2'b10
   } ref_e;

   typedef struct packed {
      ref_e       refm;
      logic [1:0] rclass;
      logic [2:0] gain;
      logic [3:0] chan;
   } fields_t;
endpackage

// File: rtl/cgs_decode.sv
module cgs_decode
   import cgs_pkg::*;
(
   input  logic [ENTRY_W-1:0] entry_i,
   output fields_t            fields_o
);
   always_comb begin
      fields_o.chan   = entry_i[3:0];
      fields_o.gain   = entry_i[6:4];
      fields_o.rclass = entry_i[9:8];
      if (entry_i[10])
         fields_o.refm = REF_DIFF;
      else if (entry_i[7])
         fields_o.refm = REF_COM;
      else
         fields_o.refm = REF_GND;
   end
endmodule

// File: rtl/cgs_store.sv
module cgs_store
   import cgs_pkg::*;
#(
   parameter int DEPTH = 128,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_i,
   input  logic               wr_i,
   input  logic [ENTRY_W-1:0] wdata_i,
   input  logic [PTR_W-1:0]   rd_idx_i,
   output logic [ENTRY_W-1:0] rd_data_o,
   output logic [CNT_W-1:0]   fill_o,
   output logic               ovf_o
);
   logic [DEPTH-1:0][ENTRY_W-1:0] rows;
   logic full, do_wr;

   assign full  = (fill_o == CNT_W'(DEPTH));
   assign do_wr = wr_i && !clr_i && !full;

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      logic [ENTRY_W-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            row_q <= '0;
         else if (do_wr && fill_o == CNT_W'(i))
            row_q <= wdata_i;
      end
      assign rows[i] = row_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_o <= '0;
         ovf_o  <= 1'b0;
      end else if (clr_i) begin
         fill_o <= '0;
         ovf_o  <= 1'b0;
      end else if (wr_i) begin
         if (full)
            ovf_o <= 1'b1;
         else
            fill_o <= fill_o + CNT_W'(1);
      end
   end

   assign rd_data_o = rows[rd_idx_i];

   assert_fill_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fill_o <= CNT_W'(DEPTH));
   assert_full_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !clr_i && full) |=> (ovf_o && $stable(fill_o)));
   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (fill_o == '0 && !ovf_o));
   assert_append_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !clr_i && !full) |=> fill_o == $past(fill_o) + CNT_W'(1));
endmodule

// File: rtl/cgs_rdptr.sv
module cgs_rdptr #(
   parameter int DEPTH = 128,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             step_i,
   input  logic [CNT_W-1:0] fill_i,
   output logic [PTR_W-1:0] rd_idx_o
);
   logic at_last;
   assign at_last = (CNT_W'(rd_idx_o) == fill_i - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_idx_o <= '0;
      else if (restart_i)
         rd_idx_o <= '0;
      else if (step_i && fill_i != '0)
         rd_idx_o <= at_last ? '0 : rd_idx_o + PTR_W'(1);
   end

   assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !restart_i && fill_i != '0 && at_last) |=> rd_idx_o == '0);
   assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_i != '0 |-> CNT_W'(rd_idx_o) < fill_i);
   assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> rd_idx_o == '0);
endmodule

// File: rtl/cgs_sequencer.sv
module cgs_sequencer
   import cgs_pkg::*;
#(
   parameter int DEPTH = 128
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tbl_clr_i,
   input  logic               tbl_wr_i,
   input  logic               latch_wr_i,
   input  logic               en_wr_i,
   input  logic               en_val_i,
   input  logic [ENTRY_W-1:0] wdata_i,
   input  logic               conv_i,
   output logic [3:0]         chan_o,
   output logic [2:0]         gain_o,
   output logic [1:0]         rclass_o,
   output logic [1:0]         ref_o,
   output logic               ovf_o
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("cgs_sequencer: DEPTH must be at least 2");
   end

   logic               tbl_en_q;
   logic [ENTRY_W-1:0] latch_q;
   logic [ENTRY_W-1:0] tbl_data;
   logic [CNT_W-1:0]   fill;
   logic [PTR_W-1:0]   rd_idx;
   logic               use_tbl;
   logic               restart;
   logic [ENTRY_W-1:0] active;
   fields_t            fields;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbl_en_q <= 1'b0;
         latch_q  <= '0;
      end else begin
         if (en_wr_i)    tbl_en_q <= en_val_i;
         if (latch_wr_i) latch_q  <= wdata_i;
      end
   end

   assign restart = tbl_clr_i || (en_wr_i && en_val_i);
   assign use_tbl = tbl_en_q && (fill != '0);

   cgs_store #(.DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (tbl_clr_i),
      .wr_i      (tbl_wr_i),
      .wdata_i   (wdata_i),
      .rd_idx_i  (rd_idx),
      .rd_data_o (tbl_data),
      .fill_o    (fill),
      .ovf_o     (ovf_o)
   );

   cgs_rdptr #(.DEPTH(DEPTH)) u_rdptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .step_i    (conv_i && tbl_en_q),
      .fill_i    (fill),
      .rd_idx_o  (rd_idx)
   );

   assign active = use_tbl ? tbl_data : latch_q;

   cgs_decode u_dec (
      .entry_i  (active),
      .fields_o (fields)
   );

   assign chan_o   = fields.chan;
   assign gain_o   = fields.gain;
   assign rclass_o = fields.rclass;
   assign ref_o    = fields.refm;

   assert_latch_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tbl_en_q && !latch_wr_i && !en_wr_i) |=> $stable({chan_o, gain_o, rclass_o, ref_o}));
   assert_empty_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == '0) |-> (chan_o == latch_q[3:0] && gain_o == latch_q[6:4]));
   assert_ref_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ref_o));
endmodule

// File: tb/sim_cgs_sequencer.sv
module sim_cgs_sequencer;
   localparam int DEPTH = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tbl_clr_i = 1'b0, tbl_wr_i = 1'b0, latch_wr_i = 1'b0;
   logic        en_wr_i = 1'b0, en_val_i = 1'b0, conv_i = 1'b0;
   logic [10:0] wdata_i = '0;
   logic [3:0]  chan_o;
   logic [2:0]  gain_o;
   logic [1:0]  rclass_o, ref_o;
   logic        ovf_o;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cgs_sequencer #(.DEPTH(DEPTH)) u0 (
      .clk, .rst_n, .tbl_clr_i, .tbl_wr_i, .latch_wr_i, .en_wr_i, .en_val_i,
      .wdata_i, .conv_i, .chan_o, .gain_o, .rclass_o, .ref_o, .ovf_o
   );

   function automatic logic [10:0] expf(input logic [10:0] e);
      logic [1:0] r;
      r = e[10] ? 2'b10 : (e[7] ? 2'b01 : 2'b00);
      return {r, e[9:8], e[6:4], e[3:0]};
   endfunction

   function automatic logic [10:0] ent(input int i);
      return 11'((i * 37 + 5) % 2048);
   endfunction

   function automatic logic [10:0] obs();
      return {ref_o, rclass_o, gain_o, chan_o};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse_end();
      @(negedge clk);
      tbl_clr_i = 0; tbl_wr_i = 0; latch_wr_i = 0; en_wr_i = 0; conv_i = 0;
   endtask

   task automatic do_clr();
      @(negedge clk); tbl_clr_i = 1; pulse_end();
   endtask
   task automatic do_wr(input logic [10:0] v);
      @(negedge clk); tbl_wr_i = 1; wdata_i = v; pulse_end();
   endtask
   task automatic do_latch(input logic [10:0] v);
      @(negedge clk); latch_wr_i = 1; wdata_i = v; pulse_end();
   endtask
   task automatic do_en(input logic b);
      @(negedge clk); en_wr_i = 1; en_val_i = b; pulse_end();
   endtask
   task automatic do_conv();
      @(negedge clk); conv_i = 1; pulse_end();
   endtask

   task automatic t_reset();
      check("R11 outputs", 32'(obs()), 32'h0);
      check("R11 ovf", 32'(ovf_o), 32'h0);
   endtask

   task automatic t_decode();
      logic [10:0] pats [6] = '{11'h000, 11'h07F, 11'h1A5, 11'h2C3, 11'h4B9, 11'h7FF};
      foreach (pats[k]) begin
         do_latch(pats[k]);
         check("R1 R2 R3 decode", 32'(obs()), 32'(expf(pats[k])));
      end
      do_latch(11'h08A);
      check("R3 common ref", 32'(ref_o), 32'h1);
      do_latch(11'h20C);
      check("R2 unipolar class", 32'(rclass_o), 32'h2);
   endtask

   task automatic t_latch_mode();
      do_clr();
      do_wr(11'h123); do_wr(11'h456);
      do_latch(11'h35A);
      do_conv();
      check("R4 disabled uses latch", 32'(obs()), 32'(expf(11'h35A)));
      do_en(1'b1);
      check("R8 enable shows entry 0", 32'(obs()), 32'(expf(11'h123)));
      do_en(1'b0);
      check("R4 disable back to latch", 32'(obs()), 32'(expf(11'h35A)));
   endtask

   task automatic t_step_wrap();
      do_clr(); do_en(1'b1);
      for (int i = 0; i < 3; i++) do_wr(ent(i));
      check("R6 entry 0", 32'(obs()), 32'(expf(ent(0))));
      do_conv();
      check("R6 entry 1", 32'(obs()), 32'(expf(ent(1))));
      do_conv();
      check("R6 entry 2", 32'(obs()), 32'(expf(ent(2))));
      do_conv();
      check("R7 wrap to 0", 32'(obs()), 32'(expf(ent(0))));
      do_conv(); do_conv();
      do_en(1'b1);
      check("R8 re-enable restarts", 32'(obs()), 32'(expf(ent(0))));
      do_conv();
      do_clr();
      check("R9 enabled empty uses latch", 32'(obs()), 32'(expf(11'h35A)));
      @(negedge clk); tbl_clr_i = 1; tbl_wr_i = 1; wdata_i = 11'h111; pulse_end();
      check("R5 clear beats write", 32'(obs()), 32'(expf(11'h35A)));
   endtask

   task automatic t_overflow();
      do_clr(); do_en(1'b1);
      for (int i = 0; i < DEPTH; i++) do_wr(ent(i));
      check("R10 no ovf when just full", 32'(ovf_o), 32'h0);
      do_wr(11'h7AB);
      check("R10 ovf set", 32'(ovf_o), 32'h1);
      for (int i = 1; i < DEPTH; i++) do_conv();
      check("R6 last entry", 32'(obs()), 32'(expf(ent(DEPTH - 1))));
      do_conv();
      check("R10 extra write ignored, R7 wrap", 32'(obs()), 32'(expf(ent(0))));
      do_wr(11'h7AB);
      check("R10 ovf sticky", 32'(ovf_o), 32'h1);
      do_clr();
      check("R5 clear drops ovf", 32'(ovf_o), 32'h0);
      do_wr(11'h0F1);
      check("R5 refill from slot 0", 32'(obs()), 32'(expf(11'h0F1)));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_decode();
      t_latch_mode();
      t_step_wrap();
      t_overflow();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule